// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is a serial test port for a chip's pins. A test clock (`tck_i`) and a mode-select line (`tms_i`) drive a sixteen-state controller. A serial input (`tdi_i`) shifts into whichever register the current instruction selects, and the register's low bit leaves on `tdo_o`.

The block holds four registers that can be scanned:
- a 3-bit instruction register;
- a single-bit bypass stage;
- a 32-bit identification word;
- a boundary chain whose length is a parameter (109 cells by default).

The first cells of the boundary chain observe a small set of stub pins and the core's drive values for those pins. A separate update latch can take over the pin outputs during an external test.

In a system, a tester walks the controller through the data or instruction columns of the state diagram. It loads an instruction, then captures, shifts and updates the selected data register. Holding the mode line high always returns the port to its reset state, and that state selects the identification word.

Top module: `tap_top`

## Requirements
- R1: Asynchronous reset, and every pass through Test-Logic-Reset, selects the identification instruction (code 3'b001). The `tdo_en_o` output is low after reset, and `pins_o` follows `core_i`.
- R2: Five consecutive rising edges of `tck_i` with `tms_i` high bring the controller to Test-Logic-Reset from any state. The controller follows the standard sixteen-state diagram.
- R3: The instruction register is 3 bits wide and shifts least significant bit first. In Capture-IR it loads 3'b001, so the first bits out are 1, 0, 0. A new code takes effect on the rising edge that leaves Update-IR.
- R4: The identification register captures {revision[2:0], device[16:0], vendor[10:0], 1'b1}, with the revision in bits 31:29 and the marker 1 in bit 0. The register is 32 cells long between `tdi_i` and `tdo_o`.
- R5: Code 3'b111 selects the single-bit bypass stage. It captures 0, and each `tdi_i` bit appears on `tdo_o` one shift later.
- R6: The codes 3'b010, 3'b011, 3'b101 and 3'b110 behave exactly like bypass.
- R7: Code 3'b100 (sample/preload) and code 3'b000 (external test) select the boundary chain. In Capture-DR, cells 0..NPIN-1 take `pins_i`, cells NPIN..2*NPIN-1 take `core_i`, and all other cells take 0.
- R8: In Update-DR under 3'b100 or 3'b000, cells NPIN..2*NPIN-1 load the update latch. Under 3'b000, `pins_o` shows the latch; otherwise `pins_o` equals `core_i`. A pattern preloaded under 3'b100 therefore appears on the pins as soon as 3'b000 becomes current.
- R9: `tdo_o` and `tdo_en_o` change on the falling edge of `tck_i`. `tdo_en_o` is high only while the controller is in Shift-IR or Shift-DR.
- R10: The boundary chain is BSR_LEN cells long, so a bit entering on `tdi_i` leaves on `tdo_o` BSR_LEN shifts later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tms_i | input | 1 | Mode select, sampled on rising edge |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, updated on falling edge |
| tdo_en_o | output | 1 | High while a shift state is active |
| pins_i | input | NPIN | Observed pin levels |
| core_i | input | NPIN | Core drive values for the pins |
| pins_o | output | NPIN | Pin drive: core values, or update latch in external test |

## Verification
The bench first runs directed scans. Scans of the identification, bypass and boundary registers tell the three data-register lengths and capture values apart. A preload-then-external-test sequence separates the update latch from the live core values. Random mode-line walks that end in five high cycles show that the reset path works from arbitrary states. Random instruction codes with random pin and core values check that every code routes the matching register, including the unused codes that must act as bypass.

// File: rtl/tap_pkg.sv
package tap_pkg;
  typedef enum logic [3:0] {
    ST_TLR, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] INS_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] INS_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] INS_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] INS_BYPASS = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BSR} dr_sel_e;

  function automatic dr_sel_e decode_ir(input logic [IR_W-1:0] ir);
    case (ir)
      INS_IDCODE:             return SEL_ID;
      INS_EXTEST, INS_SAMPLE: return SEL_BSR;
      default:                return SEL_BYP;
    endcase
  endfunction

  function automatic tap_state_e next_state(input tap_state_e s, input logic tms);
    case (s)
      ST_TLR:    return tms ? ST_TLR    : ST_IDLE;
      ST_IDLE:   return tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: return tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: return tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: return tms ? ST_SEL_DR : ST_IDLE;
      default:   return ST_TLR;
    endcase
  endfunction
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_TLR;
    else         state_q <= next_state(state_q, tms_i);
  end

  assign state_o = state_q;

  assert_tms_reset_R2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    ($past(tms_i, 1) && $past(tms_i, 2) && $past(tms_i, 3) && $past(tms_i, 4) && $past(tms_i, 5))
      |-> state_q == ST_TLR);

  assert_tlr_hold_R2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_TLR && tms_i) |=> state_q == ST_TLR);
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] ir_o,
  output logic            ir_tdo_o
);
  logic [IR_W-1:0] sr_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= IR_CAPTURE;
    else if (state_i == ST_CAP_IR) sr_q <= IR_CAPTURE;
    else if (state_i == ST_SH_IR)  sr_q <= {tdi_i, sr_q[IR_W-1:1]};
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) ir_q <= INS_IDCODE;
    else if (state_i == ST_TLR)    ir_q <= INS_IDCODE;
    else if (state_i == ST_UPD_IR) ir_q <= sr_q;
  end

  assign ir_o     = ir_q;
  assign ir_tdo_o = sr_q[0];

  assert_tlr_idcode_R1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i == ST_TLR |=> ir_q == INS_IDCODE);

  assert_ir_capture_R3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i == ST_CAP_IR |=> sr_q[1:0] == 2'b01);

  assert_ir_stable_R3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !(state_i == ST_UPD_IR || state_i == ST_TLR) |=> $stable(ir_q));
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int          BSR_LEN = 109,
  parameter int          NPIN    = 4,
  parameter logic [31:0] ID_WORD = 32'h0000_0001
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic [IR_W-1:0] ir_i,
  input  logic            tdi_i,
  input  logic [NPIN-1:0] pins_i,
  input  logic [NPIN-1:0] core_i,
  output logic [NPIN-1:0] upd_o,
  output logic            dr_tdo_o
);
  localparam int CORE_LO = NPIN;

  dr_sel_e              sel;
  logic                 byp_q;
  logic [31:0]          id_q;
  logic [BSR_LEN-1:0]   bsr_q, bsr_cap;
  logic [NPIN-1:0]      upd_q;

  assign sel = decode_ir(ir_i);

  for (genvar k = 0; k < BSR_LEN; k++) begin : g_cell
    if (k < NPIN) begin : g_pin
      assign bsr_cap[k] = pins_i[k];
    end else if (k < 2*NPIN) begin : g_core
      assign bsr_cap[k] = core_i[k-CORE_LO];
    end else begin : g_pad
      assign bsr_cap[k] = 1'b0;
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q <= 1'b0;
      id_q  <= ID_WORD;
      bsr_q <= '0;
    end else if (state_i == ST_CAP_DR) begin
      byp_q <= 1'b0;
      if (sel == SEL_ID)  id_q  <= ID_WORD;
      if (sel == SEL_BSR) bsr_q <= bsr_cap;
    end else if (state_i == ST_SH_DR) begin
      case (sel)
        SEL_ID:  id_q  <= {tdi_i, id_q[31:1]};
        SEL_BSR: bsr_q <= {tdi_i, bsr_q[BSR_LEN-1:1]};
        default: byp_q <= tdi_i;
      endcase
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) upd_q <= '0;
    else if (state_i == ST_UPD_DR && sel == SEL_BSR) upd_q <= bsr_q[CORE_LO +: NPIN];
  end

  always_comb begin
    case (sel)
      SEL_ID:  dr_tdo_o = id_q[0];
      SEL_BSR: dr_tdo_o = bsr_q[0];
      default: dr_tdo_o = byp_q;
    endcase
  end

  assign upd_o = upd_q;

  assert_byp_capture_R5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_CAP_DR) |=> byp_q == 1'b0);

  assert_id_capture_R4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_CAP_DR && sel == SEL_ID) |=> (id_q[0] == 1'b1 && id_q == ID_WORD));

  assert_upd_hold_R8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i != ST_UPD_DR) |=> $stable(upd_q));
endmodule

// File: rtl/tap_top.sv
module tap_top
  import tap_pkg::*;
#(
  parameter int          BSR_LEN = 109,
  parameter int          NPIN    = 4,
  parameter logic [2:0]  ID_REV  = 3'h0,
  parameter logic [16:0] ID_DEV  = 17'h1_2A5C,
  parameter logic [10:0] ID_VEND = 11'h2B4
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            tms_i,
  input  logic            tdi_i,
  output logic            tdo_o,
  output logic            tdo_en_o,
  input  logic [NPIN-1:0] pins_i,
  input  logic [NPIN-1:0] core_i,
  output logic [NPIN-1:0] pins_o
);
  localparam logic [31:0] ID_WORD = {ID_REV, ID_DEV, ID_VEND, 1'b1};

  tap_state_e      state;
  logic [IR_W-1:0] ir;
  logic            ir_tdo, dr_tdo;
  logic [NPIN-1:0] upd;
  logic            tdo_q, tdo_en_q;

  tap_fsm u_fsm (.tck_i, .rst_ni, .tms_i, .state_o(state));

  tap_ir u_ir (.tck_i, .rst_ni, .state_i(state), .tdi_i, .ir_o(ir), .ir_tdo_o(ir_tdo));

  tap_dr #(.BSR_LEN(BSR_LEN), .NPIN(NPIN), .ID_WORD(ID_WORD)) u_dr (
    .tck_i, .rst_ni, .state_i(state), .ir_i(ir), .tdi_i,
    .pins_i, .core_i, .upd_o(upd), .dr_tdo_o(dr_tdo)
  );

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_en_q <= (state == ST_SH_IR) || (state == ST_SH_DR);
      if (state == ST_SH_IR)      tdo_q <= ir_tdo;
      else if (state == ST_SH_DR) tdo_q <= dr_tdo;
    end
  end

  assign tdo_o    = tdo_q;
  assign tdo_en_o = tdo_en_q;
  assign pins_o   = (ir == INS_EXTEST) ? upd : core_i;

  assert_tdo_en_shift_R9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_o |-> (state == ST_SH_IR || state == ST_SH_DR));

  assert_tdo_stable_R9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !tdo_en_o |=> $stable(tdo_o) || tdo_en_o);
endmodule

// File: tb/tap_top_bench.sv
module tap_top_bench;
  localparam int          BSR_LEN = 109;
  localparam int          NPIN    = 4;
  localparam logic [2:0]  REV     = 3'h5;
  localparam logic [16:0] DEV     = 17'h0_C3A7;
  localparam logic [10:0] VEND    = 11'h35B;
  localparam logic [31:0] IDW     = {REV, DEV, VEND, 1'b1};

  logic tck = 1'b0, rst_ni = 1'b0, tms_i = 1'b1, tdi_i = 1'b0;
  logic tdo_o, tdo_en_o;
  logic [NPIN-1:0] pins_i = '0, core_i = '0, pins_o;
  int checks = 0, errors = 0;

  always #2.5 tck = ~tck;

  tap_top #(.BSR_LEN(BSR_LEN), .NPIN(NPIN), .ID_REV(REV), .ID_DEV(DEV), .ID_VEND(VEND)) u_tap_top (
    .tck_i(tck), .rst_ni, .tms_i, .tdi_i, .tdo_o, .tdo_en_o, .pins_i, .core_i, .pins_o);

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic tms, input logic tdi, output logic tdo);
    tms_i = tms; tdi_i = tdi;
    @(posedge tck); @(negedge tck); #1;
    tdo = tdo_o;
  endtask

  // from Idle: scan n bits through the selected data register, back to Idle
  task automatic scan_dr(input int n, input logic [511:0] din, output logic [511:0] dout);
    logic b;
    dout = '0;
    tick(1, 0, b); tick(0, 0, b); tick(0, 0, b);
    dout[0] = b;
    chk(tdo_en_o == 1'b1, "R9 tdo_en in Shift-DR", tdo_en_o, 1);
    for (int i = 0; i < n; i++) begin
      tick(i == n-1, din[i], b);
      if (i < n-1) dout[i+1] = b;
    end
    tick(1, 0, b); tick(0, 0, b);
    chk(tdo_en_o == 1'b0, "R9 tdo_en in Idle", tdo_en_o, 0);
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
    logic b;
    tick(1, 0, b); tick(1, 0, b); tick(0, 0, b); tick(0, 0, b);
    cap[0] = b;
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, code[i], b);
      if (i < 2) cap[i+1] = b;
    end
    tick(1, 0, b); tick(0, 0, b);
  endtask

  function automatic int dr_len(input logic [2:0] c);
    if (c == 3'b001) return 32;
    if (c == 3'b000 || c == 3'b100) return BSR_LEN;
    return 1;
  endfunction

  function automatic logic [511:0] exp_cap(input logic [2:0] c, input logic [NPIN-1:0] p, input logic [NPIN-1:0] k);
    logic [511:0] v = '0;
    if (c == 3'b001) v[31:0] = IDW;
    else if (c == 3'b000 || c == 3'b100) begin
      v[NPIN-1:0] = p;
      v[2*NPIN-1:NPIN] = k;
    end
    return v;
  endfunction

  // scans code's register with a random tail and checks capture and length
  task automatic check_code(input logic [2:0] c, input string req);
    logic [511:0] din, dout, exp;
    int l = dr_len(c);
    din = {16{$urandom()}};
    scan_dr(l + 16, din, dout);
    exp = exp_cap(c, pins_i, core_i);
    for (int i = 0; i < l; i++)
      if (dout[i] !== exp[i]) begin
        chk(0, {req, " capture"}, dout, exp); return;
      end
    chk(1, req, 0, 0);
    chk(dout[l +: 16] == din[15:0], {req, " length"}, dout[l +: 16], din[15:0]);
  endtask

  initial begin
    logic [511:0] din, dout;
    logic [2:0] cap;
    logic b;
    void'($urandom(32'd1234));
    fork
      begin
        repeat (150000) @(posedge tck);
        chk(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    core_i = 4'hA; pins_i = 4'h6;
    repeat (3) @(negedge tck);
    #1;
    chk(tdo_en_o == 0, "R1 tdo_en after reset", tdo_en_o, 0);
    chk(pins_o == core_i, "R1 pins_o after reset", pins_o, core_i);
    rst_ni = 1'b1;
    tick(0, 0, b);

    check_code(3'b001, "R1 R4 idcode after reset");
    scan_dr(32, '0, dout);
    chk(dout[31:0] == IDW && dout[0] == 1'b1, "R4 id fields", dout[31:0], IDW);

    load_ir(3'b111, cap);
    chk(cap == 3'b001, "R3 IR capture", cap, 3'b001);
    check_code(3'b111, "R5 bypass");

    foreach (cap[i]) ;
    check_code(3'b111, "R5 bypass repeat");
    for (int c = 0; c < 8; c++) begin
      if (c == 2 || c == 3 || c == 5 || c == 6) begin
        load_ir(c[2:0], cap);
        chk(cap == 3'b001, "R3 IR capture", cap, 3'b001);
        check_code(c[2:0], "R6 unused code");
      end
    end

    load_ir(3'b100, cap);
    pins_i = 4'h9; core_i = 4'h3;
    check_code(3'b100, "R7 R10 sample");
    chk(pins_o == core_i, "R8 pins_o in sample", pins_o, core_i);

    // preload 0x5 into the core-side cells, then switch to external test
    din = '0; din[2*NPIN-1:NPIN] = 4'h5;
    scan_dr(BSR_LEN, din, dout);
    chk(pins_o == core_i, "R8 preload not driven yet", pins_o, core_i);
    load_ir(3'b000, cap);
    chk(pins_o == 4'h5, "R8 extest drives preload", pins_o, 4'h5);
    core_i = 4'hC;
    #1 chk(pins_o == 4'h5, "R8 extest ignores core", pins_o, 4'h5);
    check_code(3'b000, "R7 R10 extest capture");

    // R2 random walks then five TMS highs
    for (int it = 0; it < 20; it++) begin
      load_ir(3'b111, cap);
      for (int j = 0; j < int'($urandom_range(1, 30)); j++) tick($urandom_range(0, 1), $urandom_range(0, 1), b);
      for (int j = 0; j < 5; j++) tick(1, 0, b);
      tick(0, 0, b);
      scan_dr(32, '0, dout);
      chk(dout[31:0] == IDW, "R2 R1 five TMS highs reset", dout[31:0], IDW);
    end

    // random codes with random pin values
    for (int it = 0; it < 40; it++) begin
      logic [2:0] c = 3'($urandom());
      pins_i = 4'($urandom()); core_i = 4'($urandom());
      load_ir(c, cap);
      chk(cap == 3'b001, "R3 IR capture", cap, 3'b001);
      check_code(c, "R5 R6 R7 random code");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule